// File: doc/BRIEF.md
# Byte-Loaded Match/Overflow PWM Channel

This block is a single compare channel driven by its own free-running timebase counter. The counter width is two bytes (16 bits with the default byte width). The channel output is a set/reset latch. It is set in the cycle after the counter equals the loaded compare value, and it is cleared in the cycle after the counter wraps back to zero. The number of high cycles per counter period is therefore the full period minus the compare value. A compare value of zero gives a constant high level, and the all-ones value gives a single high cycle per period.

Software loads the compare value through a narrow byte-wide write port, one byte per write. Writing the low byte turns the comparator off and writing the high byte turns it back on. A two-byte update therefore never acts on a half-written value, provided the low byte is written first. Leaving the comparator off after a low-byte write holds the output low from the next wrap on, which gives a 0% duty cycle. Two mode bits must both be set for the channel to run. A sticky match flag and a sticky overflow flag record the output edges. Each flag can raise the interrupt request through its own enable bit, and software clears each flag with an explicit write.

Top module: `pwm16_match_chan`

## Requirements
- R1: After a synchronous reset the counter, compare value, comparator enable, mode bits, interrupt enables, both flags, `pwm_out` and `irq` are all 0.
- R2: When `run` is 1, `tb_count` increases by one on each clock and wraps from all-ones to 0. When `run` is 0, `tb_count` holds its value.
- R3: While the channel is active and `run` is 1, a cycle in which `tb_count` equals the compare value makes `pwm_out` 1 from the next cycle on.
- R4: A wrap of the counter clears `pwm_out`. The output is low in the cycle in which `tb_count` first reads 1 after the wrap.
- R5: With an active channel and compare value C, `pwm_out` is high for exactly 2^W − C cycles of each 2^W-cycle period, where W is the counter width. With C = all-ones this is 1 cycle.
- R6: When a match and a wrap act on the same clock edge (C = 0), the match wins and `pwm_out` stays high for the whole period.
- R7: A write to address 0 loads the low compare byte and clears the comparator enable. A write to address 1 loads the high compare byte and sets the enable. With the enable at 0, no match acts, and `pwm_out` stays low from the first wrap on.
- R8: The channel is active only when the comparator enable, mode bit 0 (PWM mode) and mode bit 1 (wide mode) are all 1. The mode register is at address 2.
- R9: If mode bit 2 is 1, each acting match sets `match_flag` on the same edge on which `pwm_out` rises. If mode bit 2 is 0, `match_flag` is not set.
- R10: Each counter wrap sets `ovf_flag` on the same edge on which the wrap clears `pwm_out`, whatever the mode bits are.
- R11: Both flags are sticky. Writing address 4 with bit 0 = 1 clears `match_flag`, and with bit 1 = 1 clears `ovf_flag`. If a flag is set and cleared on the same edge, the set wins.
- R12: `irq` = (`match_flag` AND bit 0 of address 3) OR (`ovf_flag` AND bit 1 of address 3).
- R13: A compare value changed in the middle of a period takes effect at the next equality with the counter. The old value does not act once it has been replaced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Timebase advance enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 low byte, 1 high byte, 2 mode, 3 interrupt enables, 4 flag clear) |
| wr_data | input | BYTE_W | Write data |
| tb_count | output | 2*BYTE_W | Timebase counter value |
| pwm_out | output | 1 | PWM output latch |
| match_flag | output | 1 | Sticky match flag |
| ovf_flag | output | 1 | Sticky counter-wrap flag |
| irq | output | 1 | Interrupt request |

## Verification
A match and a counter wrap land on the same clock edge when the compare value is 0. One event wants to set the output latch and the other wants to clear it. The bench loads 0 and counts the high cycles over a full period; it expects all of them to be high. It also checks that both flags are set after that one edge. A second collision is a flag-clear write on the very edge on which the wrap sets the overflow flag. The bench times that write so that it lands on this edge, and it expects the overflow flag to survive while the match flag, which has no set pending, is cleared.

// File: rtl/pwm16_pkg.sv
package pwm16_pkg;

    // Register address map of the channel write port
    localparam int ADDR_W = 3;
    localparam int LANES  = 2;   // compare register is two bytes wide

    typedef enum logic [ADDR_W-1:0] {
        REG_CMP_LO   = 3'd0,
        REG_CMP_HI   = 3'd1,
        REG_MODE     = 3'd2,
        REG_IRQ_EN   = 3'd3,
        REG_FLAG_CLR = 3'd4
    } reg_addr_e;

    // Bit positions inside the mode, interrupt-enable and clear registers
    localparam int MODE_PWM_BIT   = 0;
    localparam int MODE_WIDE_BIT  = 1;
    localparam int MODE_MFLAG_BIT = 2;
    localparam int IRQ_MATCH_BIT  = 0;
    localparam int IRQ_OVF_BIT    = 1;
    localparam int CLR_MATCH_BIT  = 0;
    localparam int CLR_OVF_BIT    = 1;

    typedef struct packed {
        logic pwm;
        logic wide;
        logic mflag_en;
    } mode_t;

    typedef struct packed {
        logic match_en;
        logic ovf_en;
    } irq_en_t;

    typedef struct packed {
        logic clr_match;
        logic clr_ovf;
    } clr_t;

    typedef struct packed {
        logic match;
        logic wrap;
    } evt_t;

    function automatic logic chan_active(mode_t m, logic cmp_en);
        return cmp_en & m.pwm & m.wide;
    endfunction

    function automatic logic irq_merge(logic mflag, logic oflag, irq_en_t en);
        return (mflag & en.match_en) | (oflag & en.ovf_en);
    endfunction

endpackage

// File: rtl/pwm16_timebase.sv
module pwm16_timebase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    output logic [CNT_W-1:0] count,
    output logic             wrap_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // wrap_q is high during the cycle in which the counter has just rolled to 0
    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            wrap_q <= 1'b0;
        end else begin
            wrap_q <= run && (count == CNT_MAX);
            if (run) begin
                count <= count + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/pwm16_cmp_regs.sv
module pwm16_cmp_regs
    import pwm16_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [BYTE_W-1:0]         wr_data,
    output logic [LANES*BYTE_W-1:0]   cmp,
    output logic                      cmp_en,
    output mode_t                     mode,
    output irq_en_t                   irq_en,
    output clr_t                      clr
);
    localparam int CMP_W = LANES * BYTE_W;

    logic wr_lo, wr_hi, wr_mode, wr_irq, wr_clr;

    assign wr_lo   = wr_en && (wr_addr == REG_CMP_LO);
    assign wr_hi   = wr_en && (wr_addr == REG_CMP_HI);
    assign wr_mode = wr_en && (wr_addr == REG_MODE);
    assign wr_irq  = wr_en && (wr_addr == REG_IRQ_EN);
    assign wr_clr  = wr_en && (wr_addr == REG_FLAG_CLR);

    // One byte lane per address, lane b at address b
    for (genvar b = 0; b < LANES; b++) begin : g_lane
        logic [BYTE_W-1:0] lane_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                lane_q <= '0;
            end else if (wr_en && (wr_addr == ADDR_W'(b))) begin
                lane_q <= wr_data;
            end
        end
        assign cmp[b*BYTE_W +: BYTE_W] = lane_q;
    end

    // Enable gating: low byte disarms, high byte re-arms
    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_en <= 1'b0;
        end else if (wr_lo) begin
            cmp_en <= 1'b0;
        end else if (wr_hi) begin
            cmp_en <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode   <= '0;
            irq_en <= '0;
        end else begin
            if (wr_mode) begin
                mode.pwm      <= wr_data[MODE_PWM_BIT];
                mode.wide     <= wr_data[MODE_WIDE_BIT];
                mode.mflag_en <= wr_data[MODE_MFLAG_BIT];
            end
            if (wr_irq) begin
                irq_en.match_en <= wr_data[IRQ_MATCH_BIT];
                irq_en.ovf_en   <= wr_data[IRQ_OVF_BIT];
            end
        end
    end

    assign clr.clr_match = wr_clr && wr_data[CLR_MATCH_BIT];
    assign clr.clr_ovf   = wr_clr && wr_data[CLR_OVF_BIT];

    logic [CMP_W-1:0] unused_cmp_w;
    assign unused_cmp_w = cmp;

endmodule

// File: rtl/pwm16_out_latch.sv
module pwm16_out_latch
    import pwm16_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cmp,
    input  logic             active,
    input  logic             mflag_en,
    input  logic             wrap_q,
    input  clr_t             clr,
    output evt_t             evt,
    output logic             pwm_out,
    output logic             match_flag,
    output logic             ovf_flag
);
    assign evt.match = active && run && (count == cmp);
    assign evt.wrap  = wrap_q;

    // Set/reset latch: match has priority over the wrap
    always_ff @(posedge clk) begin
        if (rst) begin
            pwm_out <= 1'b0;
        end else if (evt.match) begin
            pwm_out <= 1'b1;
        end else if (evt.wrap) begin
            pwm_out <= 1'b0;
        end
    end

    // Sticky flags: a set on the same edge as a clear wins
    always_ff @(posedge clk) begin
        if (rst) begin
            match_flag <= 1'b0;
            ovf_flag   <= 1'b0;
        end else begin
            if (evt.match && mflag_en) begin
                match_flag <= 1'b1;
            end else if (clr.clr_match) begin
                match_flag <= 1'b0;
            end
            if (evt.wrap) begin
                ovf_flag <= 1'b1;
            end else if (clr.clr_ovf) begin
                ovf_flag <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pwm16_match_chan.sv
module pwm16_match_chan
    import pwm16_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    run,
    input  logic                    wr_en,
    input  logic [2:0]              wr_addr,
    input  logic [BYTE_W-1:0]       wr_data,
    output logic [2*BYTE_W-1:0]     tb_count,
    output logic                    pwm_out,
    output logic                    match_flag,
    output logic                    ovf_flag,
    output logic                    irq
);
    localparam int CNT_W = LANES * BYTE_W;

    logic [CNT_W-1:0] count_s;
    logic [CNT_W-1:0] cmp_s;
    logic             wrap_s;
    logic             cmp_en_s;
    logic             active_s;
    mode_t            mode_s;
    irq_en_t          irq_en_s;
    clr_t             clr_s;
    evt_t             evt_s;

    pwm16_timebase #(.CNT_W(CNT_W)) u_timebase (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .count  (count_s),
        .wrap_q (wrap_s)
    );

    pwm16_cmp_regs #(.BYTE_W(BYTE_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cmp     (cmp_s),
        .cmp_en  (cmp_en_s),
        .mode    (mode_s),
        .irq_en  (irq_en_s),
        .clr     (clr_s)
    );

    assign active_s = chan_active(mode_s, cmp_en_s);

    pwm16_out_latch #(.CNT_W(CNT_W)) u_latch (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .count      (count_s),
        .cmp        (cmp_s),
        .active     (active_s),
        .mflag_en   (mode_s.mflag_en),
        .wrap_q     (wrap_s),
        .clr        (clr_s),
        .evt        (evt_s),
        .pwm_out    (pwm_out),
        .match_flag (match_flag),
        .ovf_flag   (ovf_flag)
    );

    assign tb_count = count_s;
    assign irq      = irq_merge(match_flag, ovf_flag, irq_en_s);

    logic unused_evt;
    assign unused_evt = evt_s.match ^ evt_s.wrap;

endmodule

// File: rtl/pwm16_match_chan_chk.sv
module pwm16_match_chan_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             run,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] cmp,
    input logic             active,
    input logic             wr_en,
    input logic [2:0]       wr_addr,
    input logic             cmp_en,
    input logic             wrap_q,
    input logic             pwm_out,
    input logic             match_flag,
    input logic             ovf_flag,
    input logic             clr_match,
    input logic             clr_ovf
);
    a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
        run |=> count == $past(count) + CNT_W'(1));

    a_r2_count_hold: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(count));

    a_r3_match_sets: assert property (@(posedge clk) disable iff (rst)
        (active && run && count == cmp) |=> pwm_out);

    a_r3_rise_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(pwm_out) |-> $past(active && run && count == cmp));

    a_r4_wrap_clears: assert property (@(posedge clk) disable iff (rst)
        (wrap_q && !(active && run && count == cmp)) |=> !pwm_out);

    a_r7_lo_disarms: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 3'd0) |=> !cmp_en);

    a_r7_hi_arms: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 3'd1) |=> cmp_en);

    a_r10_wrap_flag: assert property (@(posedge clk) disable iff (rst)
        wrap_q |=> ovf_flag);

    a_r11_match_sticky: assert property (@(posedge clk) disable iff (rst)
        (match_flag && !clr_match) |=> match_flag);

    a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !clr_ovf) |=> ovf_flag);

endmodule

bind pwm16_match_chan pwm16_match_chan_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .count      (count_s),
    .cmp        (cmp_s),
    .active     (active_s),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .cmp_en     (cmp_en_s),
    .wrap_q     (wrap_s),
    .pwm_out    (pwm_out),
    .match_flag (match_flag),
    .ovf_flag   (ovf_flag),
    .clr_match  (clr_s.clr_match),
    .clr_ovf    (clr_s.clr_ovf)
);

// File: tb/pwm16_match_chan_tb.sv
module pwm16_match_chan_tb;
    localparam int BW     = 4;
    localparam int CW     = 2 * BW;
    localparam int PERIOD = 1 << CW;

    localparam logic [2:0] A_LO = 3'd0, A_HI = 3'd1, A_MODE = 3'd2,
                           A_IRQ = 3'd3, A_CLR = 3'd4;
    // mode bits: 0 PWM, 1 wide, 2 match flag enable
    localparam logic [BW-1:0] M_FULL = 4'b0111, M_NOFLAG = 4'b0011,
                              M_NOPWM = 4'b0110, M_NOWIDE = 4'b0101;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          run = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [BW-1:0] wr_data = '0;
    logic [CW-1:0] tb_count;
    logic          pwm_out, match_flag, ovf_flag, irq;

    int checks = 0;
    int errors = 0;
    logic [CW-1:0] m_cnt;

    pwm16_match_chan #(.BYTE_W(BW)) u_dut (
        .clk(clk), .rst(rst), .run(run), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tb_count(tb_count), .pwm_out(pwm_out),
        .match_flag(match_flag), .ovf_flag(ovf_flag), .irq(irq)
    );

    always #5 clk = ~clk;

    // Expected counter value from R2
    always @(posedge clk) begin
        if (rst) m_cnt <= '0;
        else if (run) m_cnt <= m_cnt + 1'b1;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [BW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_cnt(input int v);
        do @(negedge clk); while (int'(m_cnt) != v);
    endtask

    task automatic load_cmp(input logic [CW-1:0] c);
        wr(A_LO, c[BW-1:0]);
        wr(A_HI, c[CW-1:BW]);
    endtask

    // Counts high cycles from count 1 through count 0 of the next period
    task automatic measure(output int n);
        wait_cnt(1);
        n = 0;
        for (int i = 0; i < PERIOD; i++) begin
            if (pwm_out) n++;
            if (i != PERIOD - 1) @(negedge clk);
        end
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "count", int'(tb_count), 0);
        chk("R1", "pwm_out", int'(pwm_out), 0);
        chk("R1", "flags", int'({match_flag, ovf_flag}), 0);
        chk("R1", "irq", int'(irq), 0);
        rst = 1'b0;
        run = 1'b1;
    endtask

    task automatic t_timebase;
        wait_cnt(250);
        chk("R2", "count at 250", int'(tb_count), 250);
        run = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2", "count holds", int'(tb_count), 250);
        run = 1'b1;
        wr(A_CLR, 4'b0011);
        wait_cnt(0);
        chk("R2", "count wraps", int'(tb_count), 0);
        chk("R10", "ovf flag before edge", int'(ovf_flag), 0);
        @(negedge clk);
        chk("R10", "ovf flag after wrap", int'(ovf_flag), 1);
    endtask

    task automatic t_duty;
        int n;
        wr(A_MODE, M_FULL);
        load_cmp(8'h40);
        wait_cnt(8'h40);
        chk("R3", "low at equality", int'(pwm_out), 0);
        @(negedge clk);
        chk("R3", "high after equality", int'(pwm_out), 1);
        chk("R9", "match flag with rise", int'(match_flag), 1);
        wait_cnt(0);
        chk("R4", "high at count 0", int'(pwm_out), 1);
        @(negedge clk);
        chk("R4", "low after wrap", int'(pwm_out), 0);
        measure(n);
        chk("R5", "high cycles C=0x40", n, PERIOD - 8'h40);
        load_cmp(8'hFF);
        measure(n);
        chk("R5", "high cycles C=max", n, 1);
        load_cmp(8'h00);
        wr(A_CLR, 4'b0011);
        measure(n);
        chk("R6", "high cycles C=0", n, PERIOD);
        chk("R6", "match flag on collision", int'(match_flag), 1);
        chk("R6", "ovf flag on collision", int'(ovf_flag), 1);
    endtask

    task automatic t_disable;
        int n;
        load_cmp(8'h40);
        wr(A_LO, 4'h0);
        wr(A_CLR, 4'b0011);
        measure(n);
        chk("R7", "high cycles with enable off", n, 0);
        chk("R7", "no match flag while off", int'(match_flag), 0);
        wr(A_HI, 4'h4);
        measure(n);
        chk("R7", "high cycles after re-arm", n, PERIOD - 8'h40);
    endtask

    task automatic t_mode;
        int n;
        wr(A_MODE, M_NOPWM);
        measure(n);
        chk("R8", "no PWM bit", n, 0);
        wr(A_MODE, M_NOWIDE);
        measure(n);
        chk("R8", "no wide bit", n, 0);
        wr(A_MODE, M_FULL);
        measure(n);
        chk("R8", "all bits set", n, PERIOD - 8'h40);
    endtask

    task automatic t_mflag_en;
        wr(A_MODE, M_NOFLAG);
        wr(A_CLR, 4'b0001);
        wait_cnt(8'h41);
        chk("R9", "output rises without flag enable", int'(pwm_out), 1);
        chk("R9", "flag stays clear", int'(match_flag), 0);
        wr(A_MODE, M_FULL);
        wait_cnt(8'h41);
        chk("R9", "flag set with enable", int'(match_flag), 1);
    endtask

    task automatic t_irq;
        wr(A_IRQ, 4'b0001);
        wr(A_CLR, 4'b0011);
        wait_cnt(8'h30);
        chk("R12", "irq idle", int'(irq), 0);
        wait_cnt(8'h41);
        chk("R12", "irq from match", int'(irq), 1);
        wr(A_CLR, 4'b0001);
        chk("R11", "match flag cleared", int'(match_flag), 0);
        chk("R12", "irq drops", int'(irq), 0);
        wr(A_IRQ, 4'b0010);
        wait_cnt(1);
        chk("R12", "irq from overflow", int'(irq), 1);
        wr(A_IRQ, 4'b0000);
        chk("R12", "irq masked", int'(irq), 0);
        chk("R11", "ovf flag sticky", int'(ovf_flag), 1);
    endtask

    task automatic t_set_wins;
        wait_cnt(8'h50);
        chk("R11", "match flag set before", int'(match_flag), 1);
        wait_cnt(8'hFF);
        wr(A_CLR, 4'b0011);  // lands on the edge from count 0 to 1
        chk("R11", "ovf set beats clear", int'(ovf_flag), 1);
        chk("R11", "match flag cleared", int'(match_flag), 0);
    endtask

    task automatic t_midupdate;
        int n;
        load_cmp(8'h80);
        wait_cnt(8'h0F);
        load_cmp(8'h20);
        wait_cnt(8'h20);
        chk("R13", "low at new equality", int'(pwm_out), 0);
        @(negedge clk);
        chk("R13", "high after new value", int'(pwm_out), 1);
        measure(n);
        chk("R13", "next period uses new value", n, PERIOD - 8'h20);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_timebase();
        t_duty();
        t_disable();
        t_mode();
        t_mflag_en();
        t_irq();
        t_set_wins();
        t_midupdate();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule